// File: doc/BRIEF.md
# Multi-Standard Video Timing Generator

This block produces the horizontal and vertical framing signals for a stream of digitised NTSC or PAL samples. It runs on a fast system clock and advances by one pixel on each cycle that carries a pixel-rate enable. The line length and the position of the active window come from a built-in geometry table, indexed by the video standard and by the sampling mode. The block counts pixels within each line and lines within each field. It drives an active-pixel flag, an active-line flag, active-low horizontal and vertical sync, and a field parity flag.

Two line disciplines are available. In broadcast mode every line has exactly the table length, and incoming horizontal sync pulses have no effect. In tape mode a rising edge on the horizontal sync input starts a new line at once. That mode follows a jittery source, and a line still ends on its own if no sync arrives. The standard can be selected by an input pin or found automatically. In automatic mode the block counts line starts between vertical sync edges and changes the standard only when two fields in a row agree.

All outputs are plain level signals decoded from the counters. There is no data path and no handshake: the outputs carry no backpressure and simply follow the pixel enable.

Top module: `vid_timing_gen`

## Requirements
- R1: While and just after reset, the pixel count is 0, the field line is 1 and the field parity is odd. The outputs therefore show hsync_l=0, vsync_l=0, hvalid=0, vvalid=0, odd_field=1 and std_pal=0.
- R2: In broadcast mode a line lasts exactly the table length in enabled cycles: NTSC 858/780/910 and PAL 864/944, for modes 00/01/10 and 00/01. hsync_l is low for the first 60 pixels of each line.
- R3: hvalid is high for pixel positions p with S+a <= p < S+L+b. S is the active start (NTSC 122/112/134, PAL 130/142), L is the active length (NTSC 720/640/768, PAL 720/768), and a and b are the signed two's-complement values of hv_start_adj and hv_stop_adj.
- R4: While pix_en is low, the counters and the detected standard hold their values, so every output stays unchanged.
- R5: In broadcast mode (tv_mode=1), pulses on hsync_in do not change the line timing.
- R6: In tape mode (tv_mode=0), a rising edge of hsync_in, sampled on an enabled cycle, makes the next pixel position 0 and advances the line count.
- R7: Line numbers count within each field. The odd field has 263 lines for NTSC and 313 for PAL, and the even field has 262 or 312. odd_field flips when a field ends, and vsync_l is low on lines 1 to 3 of each field.
- R8: vvalid is high for field lines n with F+c <= n <= E+d. F is 22 for NTSC and 24 for PAL, E is 261 for NTSC and 311 for PAL, and c and d are the signed values of vv_start_adj and vv_stop_adj.
- R9: Mode 10 (4x subcarrier) always runs NTSC timing. Mode 01 follows std_pal_sel even when auto_std_en=1. std_pal shows the standard in use, with 1 meaning PAL.
- R10: With auto_std_en=1 in mode 00 or 11, the first vsync_in edge only starts counting. Each later edge casts a vote: PAL if at least 288 line starts were counted since the previous edge, NTSC otherwise. The detected standard changes only when two votes in a row agree.
- R11: Mode 11 uses the same geometry as mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-rate enable |
| std_pal_sel | input | 1 | Manual standard select, 1 = PAL |
| samp_mode | input | 2 | 00 ITU-R 601, 01 square pixel, 10 4x subcarrier, 11 as 00 |
| auto_std_en | input | 1 | Enable automatic standard recognition |
| tv_mode | input | 1 | 1 = fixed-length lines, 0 = follow hsync_in |
| hsync_in | input | 1 | Horizontal sync from the sync separator |
| vsync_in | input | 1 | Vertical sync from the sync separator |
| hv_start_adj | input | 6 | Signed offset of the hvalid rising edge |
| hv_stop_adj | input | 6 | Signed offset of the hvalid falling edge |
| vv_start_adj | input | 6 | Signed offset of the first vvalid line |
| vv_stop_adj | input | 6 | Signed offset of the last vvalid line |
| hvalid | output | 1 | Active pixel window |
| hsync_l | output | 1 | Horizontal sync, active low |
| vvalid | output | 1 | Active line window |
| vsync_l | output | 1 | Vertical sync, active low |
| odd_field | output | 1 | High in the odd field |
| std_pal | output | 1 | Standard in use, 1 = PAL |

## Verification
The bench targets the borders of the geometry table and of the field. A design with a wrong table entry or an off-by-one wrap shows a line one pixel long or short, or an active window that is shifted. Negative window offsets probe the sign extension: a design that zero-extends them moves the window edges by 64. The bench walks a full NTSC frame and the first PAL field line by line. A design with the wrong field length flips parity on the wrong line, and an inclusive/exclusive slip moves the vvalid edges by one line. The automatic detector is tested with fields of 288 and 287 lines. A detector that switches on a single vote, or that uses the wrong threshold, changes std_pal one field early or at the wrong count.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int PIX_W       = 10;
  localparam int LINE_W      = 9;
  localparam int HSYNC_PIX   = 60;
  localparam int VSYNC_LINES = 3;

  localparam logic [1:0] MODE_ITU   = 2'b00;
  localparam logic [1:0] MODE_SQ    = 2'b01;
  localparam logic [1:0] MODE_4FSC  = 2'b10;
  localparam logic [1:0] MODE_SPARE = 2'b11;

  typedef struct packed {
    logic [PIX_W-1:0] total;
    logic [PIX_W-1:0] act_start;
    logic [PIX_W-1:0] act_len;
  } hgeom_t;

  function automatic hgeom_t hgeom(input logic pal, input logic [1:0] mode);
    hgeom_t g;
    if (pal) begin
      if (mode == MODE_SQ) g = '{total: 10'd944, act_start: 10'd142, act_len: 10'd768};
      else                 g = '{total: 10'd864, act_start: 10'd130, act_len: 10'd720};
    end else begin
      case (mode)
        MODE_SQ:   g = '{total: 10'd780, act_start: 10'd112, act_len: 10'd640};
        MODE_4FSC: g = '{total: 10'd910, act_start: 10'd134, act_len: 10'd768};
        default:   g = '{total: 10'd858, act_start: 10'd122, act_len: 10'd720};
      endcase
    end
    return g;
  endfunction

  function automatic logic [LINE_W-1:0] field_len(input logic pal, input logic odd);
    if (pal) return odd ? 9'd313 : 9'd312;
    else     return odd ? 9'd263 : 9'd262;
  endfunction

  function automatic logic [LINE_W-1:0] vwin_first(input logic pal);
    return pal ? 9'd24 : 9'd22;
  endfunction

  function automatic logic [LINE_W-1:0] vwin_last(input logic pal);
    return pal ? 9'd311 : 9'd261;
  endfunction

endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import vtg_pkg::*;
#(
  parameter int ADJ_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              restart,
  input  hgeom_t            geom,
  input  logic [ADJ_W-1:0]  adj_start,
  input  logic [ADJ_W-1:0]  adj_stop,
  output logic [PIX_W-1:0]  h_cnt,
  output logic              line_start,
  output logic              hsync_l,
  output logic              hvalid
);
  localparam int SW = PIX_W + 2;

  logic signed [SW-1:0] win_lo, win_hi, pos;

  assign line_start = pix_en && (restart || (h_cnt >= geom.total - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          h_cnt <= '0;
    else if (line_start) h_cnt <= '0;
    else if (pix_en)     h_cnt <= h_cnt + 1'b1;
  end

  always_comb begin
    pos    = $signed({2'b00, h_cnt});
    win_lo = $signed({2'b00, geom.act_start})
           + $signed({{(SW-ADJ_W){adj_start[ADJ_W-1]}}, adj_start});
    win_hi = $signed({2'b00, geom.act_start}) + $signed({2'b00, geom.act_len})
           + $signed({{(SW-ADJ_W){adj_stop[ADJ_W-1]}}, adj_stop});
  end

  assign hsync_l = (h_cnt >= PIX_W'(HSYNC_PIX));
  assign hvalid  = (pos >= win_lo) && (pos < win_hi);

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
  import vtg_pkg::*;
#(
  parameter int ADJ_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              pal,
  input  logic [ADJ_W-1:0]  adj_start,
  input  logic [ADJ_W-1:0]  adj_stop,
  output logic [LINE_W-1:0] line_no,
  output logic              odd,
  output logic              vsync_l,
  output logic              vvalid
);
  localparam int SW = LINE_W + 2;

  logic [LINE_W-1:0]    flen;
  logic signed [SW-1:0] win_lo, win_hi, pos;

  assign flen = field_len(pal, odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_no <= LINE_W'(1);
      odd     <= 1'b1;
    end else if (line_start) begin
      if (line_no >= flen) begin
        line_no <= LINE_W'(1);
        odd     <= ~odd;
      end else begin
        line_no <= line_no + 1'b1;
      end
    end
  end

  always_comb begin
    pos    = $signed({2'b00, line_no});
    win_lo = $signed({2'b00, vwin_first(pal)})
           + $signed({{(SW-ADJ_W){adj_start[ADJ_W-1]}}, adj_start});
    win_hi = $signed({2'b00, vwin_last(pal)})
           + $signed({{(SW-ADJ_W){adj_stop[ADJ_W-1]}}, adj_stop});
  end

  assign vsync_l = (line_no > LINE_W'(VSYNC_LINES));
  assign vvalid  = (pos >= win_lo) && (pos <= win_hi);

endmodule

// File: rtl/vtg_std_detect.sv
module vtg_std_detect #(
  parameter int CNT_W   = 11,
  parameter int PAL_MIN = 288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic vs_edge,
  output logic det_pal
);
  logic [CNT_W-1:0] fcnt;
  logic             started, have_vote, last_vote, vote;

  assign vote = (fcnt >= CNT_W'(PAL_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt      <= '0;
      started   <= 1'b0;
      have_vote <= 1'b0;
      last_vote <= 1'b0;
      det_pal   <= 1'b0;
    end else if (vs_edge) begin
      fcnt    <= '0;
      started <= 1'b1;
      if (started) begin
        last_vote <= vote;
        have_vote <= 1'b1;
        if (have_vote && (vote == last_vote)) det_pal <= vote;
      end
    end else if (line_start && (fcnt != {CNT_W{1'b1}})) begin
      fcnt <= fcnt + 1'b1;
    end
  end

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int ADJ_W     = 6,
  parameter int DET_CNT_W = 11,
  parameter int PAL_MIN   = 288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             std_pal_sel,
  input  logic [1:0]       samp_mode,
  input  logic             auto_std_en,
  input  logic             tv_mode,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [ADJ_W-1:0] hv_start_adj,
  input  logic [ADJ_W-1:0] hv_stop_adj,
  input  logic [ADJ_W-1:0] vv_start_adj,
  input  logic [ADJ_W-1:0] vv_stop_adj,
  output logic             hvalid,
  output logic             hsync_l,
  output logic             vvalid,
  output logic             vsync_l,
  output logic             odd_field,
  output logic             std_pal
);
  logic              hs_prev, vs_prev, hs_edge, vs_edge;
  logic              det_pal, auto_ok, line_start;
  logic [PIX_W-1:0]  h_cnt;
  logic [LINE_W-1:0] line_no;
  hgeom_t            geom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev <= 1'b0;
      vs_prev <= 1'b0;
    end else if (pix_en) begin
      hs_prev <= hsync_in;
      vs_prev <= vsync_in;
    end
  end

  assign hs_edge = pix_en && hsync_in && !hs_prev;
  assign vs_edge = pix_en && vsync_in && !vs_prev;

  assign auto_ok = auto_std_en && ((samp_mode == MODE_ITU) || (samp_mode == MODE_SPARE));
  assign std_pal = (samp_mode == MODE_4FSC) ? 1'b0 : (auto_ok ? det_pal : std_pal_sel);
  assign geom    = hgeom(std_pal, samp_mode);

  vtg_hcount #(.ADJ_W(ADJ_W)) u_h (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .restart(hs_edge && !tv_mode), .geom(geom),
    .adj_start(hv_start_adj), .adj_stop(hv_stop_adj),
    .h_cnt(h_cnt), .line_start(line_start),
    .hsync_l(hsync_l), .hvalid(hvalid)
  );

  vtg_vcount #(.ADJ_W(ADJ_W)) u_v (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pal(std_pal),
    .adj_start(vv_start_adj), .adj_stop(vv_stop_adj),
    .line_no(line_no), .odd(odd_field),
    .vsync_l(vsync_l), .vvalid(vvalid)
  );

  vtg_std_detect #(.CNT_W(DET_CNT_W), .PAL_MIN(PAL_MIN)) u_det (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .vs_edge(vs_edge), .det_pal(det_pal)
  );

endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_en,
  input logic       tv_mode,
  input logic       hs_edge,
  input logic       vs_edge,
  input logic [9:0] h_cnt,
  input logic [8:0] line_no,
  input logic       odd,
  input logic       det_pal
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(h_cnt) && $stable(line_no) && $stable(odd) && $stable(det_pal)); // R4

  AST_TV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && tv_mode && (h_cnt < 10'd100) |=> h_cnt == $past(h_cnt) + 10'd1); // R5

  AST_VTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && !tv_mode && hs_edge |=> h_cnt == 10'd0); // R6

  AST_PARITY_AT_FIELD_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(odd) |-> line_no == 9'd1); // R7

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_no != 9'd0) && (line_no <= 9'd313)); // R7

  AST_DETECT_ON_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(det_pal) |-> $past(vs_edge)); // R10
endmodule

bind vid_timing_gen vid_timing_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .tv_mode(tv_mode),
  .hs_edge(hs_edge), .vs_edge(vs_edge), .h_cnt(h_cnt), .line_no(line_no),
  .odd(odd_field), .det_pal(det_pal)
);

// File: tb/vid_timing_gen_tb.sv
`timescale 1ns/1ps
module vid_timing_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0, pix_en = 1'b1, std_pal_sel = 1'b0;
  logic [1:0] samp_mode = 2'b00;
  logic auto_std_en = 1'b0, tv_mode = 1'b1, hsync_in = 1'b0, vsync_in = 1'b0;
  logic [5:0] hv_start_adj = '0, hv_stop_adj = '0, vv_start_adj = '0, vv_stop_adj = '0;
  logic hvalid, hsync_l, vvalid, vsync_l, odd_field, std_pal;

  int checks = 0, errors = 0, cyc = 0, cur_line = 1;

  always #5 clk = ~clk;

  vid_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .std_pal_sel(std_pal_sel),
    .samp_mode(samp_mode), .auto_std_en(auto_std_en), .tv_mode(tv_mode),
    .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hv_start_adj(hv_start_adj), .hv_stop_adj(hv_stop_adj),
    .vv_start_adj(vv_start_adj), .vv_stop_adj(vv_stop_adj),
    .hvalid(hvalid), .hsync_l(hsync_l), .vvalid(vvalid), .vsync_l(vsync_l),
    .odd_field(odd_field), .std_pal(std_pal)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mh, mfl, mfc;
  bit modd, mph, mpv, mdet, mst, mhave, mlast;

  function automatic bit m_pal();
    bit itu = (samp_mode == 2'b00) || (samp_mode == 2'b11);
    if (samp_mode == 2'b10) return 1'b0;
    if (itu && auto_std_en) return mdet;
    return std_pal_sel;
  endfunction

  function automatic void m_geo(input bit p, output int t, output int s, output int a);
    if (p) begin
      if (samp_mode == 2'b01) begin t = 944; s = 142; a = 768; end
      else                    begin t = 864; s = 130; a = 720; end
    end else if (samp_mode == 2'b01) begin t = 780; s = 112; a = 640; end
    else if (samp_mode == 2'b10)     begin t = 910; s = 134; a = 768; end
    else                             begin t = 858; s = 122; a = 720; end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mfl = 1; modd = 1; mph = 0; mpv = 0;
      mdet = 0; mst = 0; mhave = 0; mlast = 0; mfc = 0;
    end else if (pix_en) begin
      bit p, he, ve, ls, vote;
      int t, s, a, flen;
      p = m_pal();
      m_geo(p, t, s, a);
      he = hsync_in && !mph; ve = vsync_in && !mpv;
      mph = hsync_in; mpv = vsync_in;
      ls = (!tv_mode && he) || (mh >= t - 1);
      if (ve) begin
        if (mst) begin
          vote = (mfc >= 288);
          if (mhave && vote == mlast) mdet = vote;
          mlast = vote; mhave = 1;
        end
        mst = 1; mfc = 0;
      end else if (ls) mfc++;
      if (ls) begin
        mh = 0;
        flen = p ? (modd ? 313 : 312) : (modd ? 263 : 262);
        if (mfl >= flen) begin mfl = 1; modd = !modd; end
        else mfl++;
      end else mh++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit p;
      int t, s, a, ha, hb, va, vb, vf, vl;
      p = m_pal();
      m_geo(p, t, s, a);
      ha = $signed(hv_start_adj); hb = $signed(hv_stop_adj);
      va = $signed(vv_start_adj); vb = $signed(vv_stop_adj);
      vf = p ? 24 : 22; vl = p ? 311 : 261;
      chk(hsync_l == (mh >= 60), "R2", "hsync_l vs model", hsync_l, mh >= 60);
      chk(hvalid == ((mh >= s + ha) && (mh < s + a + hb)), "R3", "hvalid vs model",
          hvalid, (mh >= s + ha) && (mh < s + a + hb));
      chk(vsync_l == (mfl > 3), "R7", "vsync_l vs model", vsync_l, mfl > 3);
      chk(odd_field == modd, "R7", "odd_field vs model", odd_field, modd);
      chk(vvalid == ((mfl >= vf + va) && (mfl <= vl + vb)), "R8", "vvalid vs model",
          vvalid, (mfl >= vf + va) && (mfl <= vl + vb));
      chk(std_pal == p, "R9", "std_pal vs model", std_pal, p);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "ALL", "watchdog expired", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset(input bit tv, input bit pal, input bit autoen);
    @(posedge clk); #1;
    rst_n = 1'b0; tv_mode = tv; std_pal_sel = pal; auto_std_en = autoen;
    samp_mode = 2'b00; hsync_in = 0; vsync_in = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_line = 1;
  endtask

  task automatic hpulse();
    @(posedge clk); #1 hsync_in = 1'b1;
    @(posedge clk); #1 hsync_in = 1'b0;
  endtask

  task automatic vpulse();
    @(posedge clk); #1 vsync_in = 1'b1;
    @(posedge clk); #1 vsync_in = 1'b0;
  endtask

  task automatic one_line();
    repeat (60) @(posedge clk);
    hpulse();
    cur_line++;
  endtask

  task automatic goto_line(input int n);
    while (cur_line < n) one_line();
    @(negedge clk);
  endtask

  task automatic wait_fall();
    bit p;
    int g = 0;
    do begin p = hsync_l; @(negedge clk); g++; end while (!(p && !hsync_l) && g < 3000);
  endtask

  task automatic meas(input int et, input int es, input int ea, input string rq);
    int idx = 0, first = -1, cnt = 0;
    bit p;
    wait_fall(); wait_fall();
    do begin
      if (hvalid) begin if (first < 0) first = idx; cnt++; end
      p = hsync_l;
      @(negedge clk);
      idx++;
    end while (!(p && !hsync_l) && idx < 3000);
    chk(idx == et, rq, "line length", idx, et);
    chk(first == es, rq, "hvalid first pixel", first, es);
    chk(cnt == ea, rq, "hvalid width", cnt, ea);
  endtask

  task automatic set_mode(input bit pal, input logic [1:0] m);
    @(posedge clk); #1 std_pal_sel = pal; samp_mode = m;
  endtask

  // ---------------- test sequence ----------------
  initial begin
    do_reset(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk(hsync_l == 0 && vsync_l == 0, "R1", "syncs low after reset", {hsync_l, vsync_l}, 0);
    chk(hvalid == 0 && vvalid == 0, "R1", "windows low after reset", {hvalid, vvalid}, 0);
    chk(odd_field == 1 && std_pal == 0, "R1", "odd/std after reset", {odd_field, std_pal}, 2);

    // geometry table, broadcast mode
    meas(858, 122, 720, "R2");
    set_mode(1'b0, 2'b01); meas(780, 112, 640, "R2");
    set_mode(1'b0, 2'b10); meas(910, 134, 768, "R2");
    set_mode(1'b1, 2'b00); meas(864, 130, 720, "R2");
    set_mode(1'b1, 2'b01); meas(944, 142, 768, "R2");
    set_mode(1'b1, 2'b11); meas(864, 130, 720, "R11");
    set_mode(1'b0, 2'b11); meas(858, 122, 720, "R11");
    set_mode(1'b1, 2'b10); meas(910, 134, 768, "R9");

    // window offsets: +3 start, -5 stop
    set_mode(1'b0, 2'b00);
    @(posedge clk); #1 hv_start_adj = 6'd3; hv_stop_adj = 6'h3B;
    meas(858, 125, 712, "R3");
    @(posedge clk); #1 hv_start_adj = '0; hv_stop_adj = '0;

    // enable held low
    begin
      bit hs, hv, vs, vv, od;
      @(posedge clk); #1 pix_en = 1'b0;
      @(negedge clk);
      hs = hsync_l; hv = hvalid; vs = vsync_l; vv = vvalid; od = odd_field;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        chk({hsync_l, hvalid, vsync_l, vvalid, odd_field} == {hs, hv, vs, vv, od}, "R4",
            "outputs frozen while idle", {hsync_l, hvalid, vsync_l, vvalid, odd_field},
            {hs, hv, vs, vv, od});
      end
      @(posedge clk); #1 pix_en = 1'b1;
    end
    for (int i = 0; i < 2000; i++) begin @(posedge clk); #1 pix_en = (i % 3) != 0; end
    @(posedge clk); #1 pix_en = 1'b1;

    // broadcast mode ignores sync input
    wait_fall();
    repeat (200) @(negedge clk);
    hpulse();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(hsync_l == 1, "R5", "no restart in broadcast mode", hsync_l, 1);
    end

    // tape mode, NTSC full frame with vertical offsets +2 / -1
    do_reset(1'b0, 1'b0, 1'b0);
    @(posedge clk); #1 vv_start_adj = 6'd2; vv_stop_adj = 6'h3F;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(hsync_l == 1, "R6", "mid-line before sync", hsync_l, 1);
    hpulse(); cur_line++;
    @(negedge clk);
    chk(hsync_l == 0, "R6", "restart on sync edge", hsync_l, 0);
    goto_line(23);  chk(vvalid == 0, "R8", "line 23 with +2", vvalid, 0);
    goto_line(24);  chk(vvalid == 1, "R8", "line 24 with +2", vvalid, 1);
    goto_line(260); chk(vvalid == 1, "R8", "line 260 with -1", vvalid, 1);
    goto_line(261); chk(vvalid == 0, "R8", "line 261 with -1", vvalid, 0);
    goto_line(263); chk(odd_field == 1, "R7", "NTSC last odd line", odd_field, 1);
    goto_line(264); chk(odd_field == 0 && vsync_l == 0, "R7", "NTSC even field start",
                        {odd_field, vsync_l}, 0);
    goto_line(267); chk(vsync_l == 1, "R7", "vsync ends after 3 lines", vsync_l, 1);
    goto_line(287); chk(vvalid == 1, "R8", "even field line 24", vvalid, 1);
    goto_line(525); chk(odd_field == 0, "R7", "NTSC last even line", odd_field, 0);
    goto_line(526); chk(odd_field == 1, "R7", "NTSC new frame", odd_field, 1);
    @(posedge clk); #1 vv_start_adj = '0; vv_stop_adj = '0;

    // tape mode, PAL odd field
    do_reset(1'b0, 1'b1, 1'b0);
    goto_line(23);  chk(vvalid == 0, "R8", "PAL line 23", vvalid, 0);
    goto_line(24);  chk(vvalid == 1, "R8", "PAL line 24", vvalid, 1);
    goto_line(311); chk(vvalid == 1, "R8", "PAL line 311", vvalid, 1);
    goto_line(312); chk(vvalid == 0, "R8", "PAL line 312", vvalid, 0);
    goto_line(313); chk(odd_field == 1, "R7", "PAL last odd line", odd_field, 1);
    goto_line(314); chk(odd_field == 0 && vsync_l == 0, "R7", "PAL even field start",
                        {odd_field, vsync_l}, 0);

    // automatic recognition
    do_reset(1'b0, 1'b0, 1'b1);
    vpulse();
    for (int i = 0; i < 288; i++) one_line();
    vpulse(); @(negedge clk);
    chk(std_pal == 0, "R10", "single PAL vote holds NTSC", std_pal, 0);
    for (int i = 0; i < 288; i++) one_line();
    vpulse(); @(negedge clk);
    chk(std_pal == 1, "R10", "two PAL votes switch", std_pal, 1);
    set_mode(1'b0, 2'b01); @(negedge clk);
    chk(std_pal == 0, "R9", "square mode ignores auto", std_pal, 0);
    set_mode(1'b0, 2'b11); @(negedge clk);
    chk(std_pal == 1, "R9", "mode 11 uses auto", std_pal, 1);
    set_mode(1'b1, 2'b10); @(negedge clk);
    chk(std_pal == 0, "R9", "4x subcarrier forces NTSC", std_pal, 0);
    @(posedge clk); #1 auto_std_en = 1'b0; samp_mode = 2'b00; std_pal_sel = 1'b0;
    @(negedge clk);
    chk(std_pal == 0, "R9", "auto off follows select", std_pal, 0);
    @(posedge clk); #1 auto_std_en = 1'b1;
    for (int i = 0; i < 287; i++) one_line();
    vpulse(); @(negedge clk);
    chk(std_pal == 1, "R10", "single 287-line vote holds PAL", std_pal, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule